// File: doc/BRIEF.md
# Priority Reference Qualifier and Selector

This block watches up to twelve candidate clock references for a timing generator, decides which of them are trustworthy, and produces the selection code that tells the downstream phase-locked loop what to follow. For each reference it receives an activity alarm and an in-range flag from upstream monitors. A reference earns a qualified status only after it has behaved well for a programmable number of one-second ticks. It loses that status on the first clock edge at which it misbehaves.

In automatic mode the block chooses, among the qualified references, the one with the best (numerically lowest, non-zero) 4-bit priority. When no candidate remains, it falls back to a holdover code if holdover history is available and to a freerun code otherwise. In manual mode the selection code simply follows a code written by software. Single-cycle event pulses report qualification gains, qualification losses and automatic changes of the selection code.

Top module: `ref_selector_top`

## Requirements
- R1: A reference whose activity alarm is low and whose in-range flag is high becomes qualified at the clock edge of the (T+1)-th tick it sees while it stays good, where T is the qualification time input (0 to 63). Ticks seen while it is not good do not count.
- R2: If a reference stops being good before it qualifies, its dwell count restarts from zero. It then needs T+1 further ticks of unbroken good behaviour.
- R3: A qualified reference loses its qualified flag at the first clock edge at which its alarm is high or its in-range flag is low.
- R4: A reference with priority 0 is never selected in automatic mode, even when it is qualified.
- R5: In automatic mode the selection code is the bit index plus one (references are numbered 1 to 12, bit i of each per-reference port is reference i+1). It names the qualified reference with the lowest non-zero priority. On equal priority, the lower index wins.
- R6: In automatic mode with no qualified, enabled reference, the selection code is 13 (holdover) when holdover_ok is high and 0 (freerun) when it is low.
- R7: In manual mode the selection code equals the manual code that was present one clock earlier, whatever the qualification state.
- R8: The selection code is registered. It reflects the qualified flags and control inputs of the previous cycle.
- R9: qual_up_evt pulses for exactly one cycle, in the cycle in which a qualified flag first reads high. qual_down_evt pulses in the same way in the cycle in which a qualified flag first reads low.
- R10: sel_change_evt pulses for one cycle together with each change of the selection code made in automatic mode. It stays low in manual mode.
- R11: After reset, all qualified flags are 0, the selection code is 0 (freerun), and all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| act_alarm | input | NUM_REFS | Activity alarm per reference, high = bad |
| in_range | input | NUM_REFS | Frequency offset within range per reference |
| prio_flat | input | NUM_REFS*PRIO_W | Priority per reference, reference i in bits [i*PRIO_W +: PRIO_W], 0 disables |
| qual_time | input | QTIME_W | Qualification dwell time in seconds |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual |
| manual_code | input | 4 | Selection code used in manual mode |
| holdover_ok | input | 1 | Holdover history is available |
| ref_qualified | output | NUM_REFS | Qualified flag per reference |
| sel_code | output | 4 | 0 freerun, 1..12 reference, 13 holdover |
| sel_change_evt | output | 1 | Automatic selection changed |
| qual_up_evt | output | 1 | Some reference became qualified |
| qual_down_evt | output | 1 | Some reference lost qualification |

## Verification
The bench builds the block with its default parameters: twelve references, 4-bit priorities and a 6-bit qualification time. Every priority tie, disabled entry and fallback code therefore appears at full size. Because the bench drives the one-second tick directly, a dwell of several ticks costs only a few dozen cycles. This makes both the exact qualifying tick and the restart after a glitch observable. With the qualification time set to zero, each table row needs only a single tick to settle, so the selection for many alarm and range patterns can be checked in a short run.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int unsigned CODE_W = 4;

    typedef logic [CODE_W-1:0] sel_code_t;

    localparam sel_code_t CODE_FREERUN  = 4'd0;
    localparam sel_code_t CODE_HOLDOVER = 4'd13;

    // per-reference qualification state with its transition strobes
    typedef struct packed {
        logic qualified;
        logic rise;
        logic fall;
    } qual_state_t;

    // result of the priority search
    typedef struct packed {
        logic      found;
        sel_code_t idx;
    } pick_t;

    // references are numbered from one, bit index from zero
    function automatic sel_code_t code_of_index(input sel_code_t idx);
        return idx + sel_code_t'(1);
    endfunction

    function automatic sel_code_t fallback_code(input logic holdover_ok);
        return holdover_ok ? CODE_HOLDOVER : CODE_FREERUN;
    endfunction

endpackage

// File: rtl/ref_qual_cell.sv
module ref_qual_cell
    import refsel_pkg::*;
#(
    parameter int unsigned QTIME_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               alarm,
    input  logic               in_range,
    input  logic [QTIME_W-1:0] qual_time,
    output qual_state_t        state
);

    logic               good;
    logic [QTIME_W-1:0] dwell_cnt;
    qual_state_t        st_q;

    assign good  = !alarm && in_range;
    assign state = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell_cnt <= '0;
            st_q      <= '0;
        end else begin
            st_q.rise <= 1'b0;
            st_q.fall <= 1'b0;
            if (!good) begin
                dwell_cnt <= '0;
                if (st_q.qualified) begin
                    st_q.qualified <= 1'b0;
                    st_q.fall      <= 1'b1;
                end
            end else if (!st_q.qualified && tick) begin
                if (dwell_cnt >= qual_time) begin
                    st_q.qualified <= 1'b1;
                    st_q.rise      <= 1'b1;
                    dwell_cnt      <= '0;
                end else begin
                    dwell_cnt <= dwell_cnt + 1'b1;
                end
            end
        end
    end

    // R3
    disq_now_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.qualified && !good) |=> !st_q.qualified);

    // R1
    qual_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.qualified) |-> $past(tick && good));

    // R9
    up_evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.rise |=> !st_q.rise);

    // R9
    down_evt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.fall |-> !st_q.qualified);

endmodule

// File: rtl/ref_prio_pick.sv
module ref_prio_pick
    import refsel_pkg::*;
#(
    parameter int unsigned NUM_REFS = 12,
    parameter int unsigned PRIO_W   = 4
) (
    input  logic [NUM_REFS-1:0] qualified,
    input  logic [PRIO_W-1:0]   prio [NUM_REFS],
    output pick_t               pick
);

    logic [PRIO_W-1:0] best_prio;

    // strict less-than keeps the lower index on a tie
    always_comb begin
        pick      = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_REFS; i++) begin
            if (qualified[i] && (prio[i] != '0) &&
                (!pick.found || (prio[i] < best_prio))) begin
                pick.found = 1'b1;
                pick.idx   = sel_code_t'(i);
                best_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl
    import refsel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      auto_mode,
    input  sel_code_t manual_code,
    input  logic      holdover_ok,
    input  pick_t     pick,
    output sel_code_t sel_code,
    output logic      change_evt
);

    sel_code_t sel_q;
    sel_code_t sel_nxt;
    logic      evt_q;

    always_comb begin
        if (!auto_mode)
            sel_nxt = manual_code;
        else if (pick.found)
            sel_nxt = code_of_index(pick.idx);
        else
            sel_nxt = fallback_code(holdover_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= CODE_FREERUN;
            evt_q <= 1'b0;
        end else begin
            sel_q <= sel_nxt;
            evt_q <= auto_mode && (sel_nxt != sel_q);
        end
    end

    assign sel_code   = sel_q;
    assign change_evt = evt_q;

    // R7
    man_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_mode |=> sel_code == $past(manual_code));

    // R10
    chg_evt_auto_chk: assert property (@(posedge clk) disable iff (rst)
        change_evt |-> ($past(auto_mode) && sel_code != $past(sel_code)));

    // R6
    fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && !pick.found) |=> (sel_code == CODE_HOLDOVER || sel_code == CODE_FREERUN));

endmodule

// File: rtl/ref_selector_top.sv
module ref_selector_top
    import refsel_pkg::*;
#(
    parameter int unsigned NUM_REFS = 12,
    parameter int unsigned PRIO_W   = 4,
    parameter int unsigned QTIME_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sec_tick,
    input  logic [NUM_REFS-1:0]        act_alarm,
    input  logic [NUM_REFS-1:0]        in_range,
    input  logic [NUM_REFS*PRIO_W-1:0] prio_flat,
    input  logic [QTIME_W-1:0]         qual_time,
    input  logic                       auto_mode,
    input  logic [3:0]                 manual_code,
    input  logic                       holdover_ok,
    output logic [NUM_REFS-1:0]        ref_qualified,
    output logic [3:0]                 sel_code,
    output logic                       sel_change_evt,
    output logic                       qual_up_evt,
    output logic                       qual_down_evt
);

    qual_state_t       qstate [NUM_REFS];
    logic [PRIO_W-1:0] prio_arr [NUM_REFS];
    logic [NUM_REFS-1:0] rise_vec;
    logic [NUM_REFS-1:0] fall_vec;
    pick_t             pick;

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
        assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];

        ref_qual_cell #(.QTIME_W(QTIME_W)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .tick      (sec_tick),
            .alarm     (act_alarm[g]),
            .in_range  (in_range[g]),
            .qual_time (qual_time),
            .state     (qstate[g])
        );

        assign ref_qualified[g] = qstate[g].qualified;
        assign rise_vec[g]      = qstate[g].rise;
        assign fall_vec[g]      = qstate[g].fall;
    end

    assign qual_up_evt   = |rise_vec;
    assign qual_down_evt = |fall_vec;

    ref_prio_pick #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W)) u_pick (
        .qualified (ref_qualified),
        .prio      (prio_arr),
        .pick      (pick)
    );

    ref_sel_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .auto_mode   (auto_mode),
        .manual_code (manual_code),
        .holdover_ok (holdover_ok),
        .pick        (pick),
        .sel_code    (sel_code),
        .change_evt  (sel_change_evt)
    );

    // R4
    pick_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        pick.found |-> (prio_arr[pick.idx] != '0 && ref_qualified[pick.idx]));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ref_qualified == '0 && sel_code == CODE_FREERUN && !sel_change_evt));

endmodule

// File: tb/tb_ref_selector_top.sv
`timescale 1ns/1ps
module tb_ref_selector_top;

    localparam int N = 12;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          sec_tick;
    logic [N-1:0]  act_alarm;
    logic [N-1:0]  in_range;
    logic [N*4-1:0] prio_flat;
    logic [5:0]    qual_time;
    logic          auto_mode;
    logic [3:0]    manual_code;
    logic          holdover_ok;
    logic [N-1:0]  ref_qualified;
    logic [3:0]    sel_code;
    logic          sel_change_evt;
    logic          qual_up_evt;
    logic          qual_down_evt;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ref_selector_top dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .act_alarm(act_alarm),
        .in_range(in_range), .prio_flat(prio_flat), .qual_time(qual_time),
        .auto_mode(auto_mode), .manual_code(manual_code), .holdover_ok(holdover_ok),
        .ref_qualified(ref_qualified), .sel_code(sel_code),
        .sel_change_evt(sel_change_evt), .qual_up_evt(qual_up_evt),
        .qual_down_evt(qual_down_evt)
    );

    // priorities of references 1..12 (index 0..11): 4,2,0,2,9,1,15,6,1,0,8,3
    localparam logic [N*4-1:0] PRIOS = 48'h3801_6F19_2024;

    localparam logic [N-1:0] V_ALM [NV] = '{12'h000, 12'h020, 12'h000, 12'h000,
                                           12'h000, 12'h002, 12'h000, 12'hFFF};
    localparam logic [N-1:0] V_RNG [NV] = '{12'hFFF, 12'hFFF, 12'h004, 12'h004,
                                           12'h00A, 12'h00A, 12'h890, 12'hFFF};
    localparam logic V_HO [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_code(input logic [N-1:0] good, input logic ho);
        logic [3:0] best_p = 4'hF;
        logic [3:0] code = ho ? 4'd13 : 4'd0;
        logic found = 1'b0;
        for (int i = 0; i < N; i++) begin
            logic [3:0] p = PRIOS[i*4 +: 4];
            if (good[i] && p != 0 && (!found || p < best_p)) begin
                found = 1'b1;
                best_p = p;
                code = 4'(i + 1);
            end
        end
        return code;
    endfunction

    task automatic tick_once();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sec_tick = 1'b0; act_alarm = '1; in_range = '0;
        prio_flat = PRIOS; qual_time = 6'd0; auto_mode = 1'b1;
        manual_code = 4'd0; holdover_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 qual", 16'(ref_qualified), 16'h0);
        check("R11 sel", 16'(sel_code), 16'h0);
        check("R11 chg", 16'(sel_change_evt), 16'h0);
        check("R11 evts", 16'({qual_up_evt, qual_down_evt}), 16'h0);

        // R5 R6 R4 R8 table walk with zero dwell time
        for (int v = 0; v < NV; v++) begin
            act_alarm = V_ALM[v]; in_range = V_RNG[v]; holdover_ok = V_HO[v];
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
            @(negedge clk);
            check("R1 R3 table qual", 16'(ref_qualified), 16'(~V_ALM[v] & V_RNG[v]));
            check("R5 R6 R4 table sel", 16'(sel_code), 16'(model_code(~V_ALM[v] & V_RNG[v], V_HO[v])));
        end

        // R1 dwell of qual_time+1 ticks on reference 1
        act_alarm = '1; in_range = '0; holdover_ok = 1'b0; qual_time = 6'd3;
        do_reset();
        act_alarm = 12'hFFE; in_range = 12'h001;
        repeat (3) tick_once();
        check("R1 not yet", 16'(ref_qualified), 16'h0);
        tick_once();
        check("R1 qualified", 16'(ref_qualified), 16'h1);
        check("R9 up pulse", 16'(qual_up_evt), 16'h1);
        @(negedge clk);
        check("R9 up single", 16'(qual_up_evt), 16'h0);
        check("R8 sel after qual", 16'(sel_code), 16'h1);
        check("R10 chg pulse", 16'(sel_change_evt), 16'h1);
        @(negedge clk);
        check("R10 chg single", 16'(sel_change_evt), 16'h0);

        // R3 immediate loss
        act_alarm = 12'hFFF;
        @(negedge clk);
        check("R3 lost", 16'(ref_qualified), 16'h0);
        check("R9 down pulse", 16'(qual_down_evt), 16'h1);
        @(negedge clk);
        check("R9 down single", 16'(qual_down_evt), 16'h0);
        check("R6 freerun", 16'(sel_code), 16'h0);

        // R2 restart after a glitch
        do_reset();
        act_alarm = 12'hFFE; in_range = 12'h001;
        repeat (2) tick_once();
        @(negedge clk); in_range = 12'h000;
        @(negedge clk); in_range = 12'h001;
        repeat (3) tick_once();
        check("R2 restarted", 16'(ref_qualified), 16'h0);
        tick_once();
        check("R2 qualified", 16'(ref_qualified), 16'h1);

        // R7 manual mode, R10 no event
        auto_mode = 1'b0; manual_code = 4'd13;
        @(negedge clk); @(negedge clk);
        check("R7 manual 13", 16'(sel_code), 16'd13);
        check("R10 manual no evt", 16'(sel_change_evt), 16'h0);
        manual_code = 4'd7;
        @(negedge clk);
        check("R7 manual 7", 16'(sel_code), 16'd7);
        check("R10 manual no evt2", 16'(sel_change_evt), 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule